// File: doc/BRIEF.md
# Fetch redirect squash tracker

This block sits beside a fetch unit that has no internal buffering. It keeps a count of the fetch memory requests still waiting for their responses. When a control-flow redirect arrives, it works out how many of those responses belong to the abandoned path, and it tells the datapath to throw them away as they come back.

It also remembers where inside the aligned fetch block the redirect target lands. Until the first good block after the redirect has been handed to decode, it marks the lanes in front of that position as invalid.

The address generator uses the in-flight count and the request-allow output to throttle new requests. The decode side uses the per-lane mask and status to skip lanes, and to hold back sequence-number allocation for them.

Top module: `fetch_squash_tracker`

## Requirements
- R1: After reset the in-flight count and the squash count are zero, no restart is pending, every lane mask bit is 1 and every lane status is READY.
- R2: The in-flight count rises by one on each accepted request and falls by one on each response that arrives and is consumed. It stays unchanged when both happen in the same cycle. A consume at a count of zero is ignored.
- R3: Requests are accepted only while the in-flight count is below MAX_INFLIGHT (default 4), and `req_allow_o` is high exactly then. A request while the count is at the limit leaves the count unchanged.
- R4: On a redirect the squash count is loaded with the in-flight count after that same cycle's request and consume have been applied.
- R5: While no redirect is present and the squash count is nonzero, each arriving response lowers the squash count by one.
- R6: `drop_o` is high in any cycle where a redirect is present or the squash count is nonzero, and low otherwise.
- R7: A redirect captures address bits [log2(NUM_LANES)+1:2] as the restart offset. While a restart is pending, lanes below the offset have mask 0 and status INVALID (2'b00), and lanes at or above it have mask 1 and status READY (2'b01). The status of lane i is held in `lane_status_o[2i+1:2i]`.
- R8: A redirect sets the restart-pending state. A block transfer with `drop_o` low clears it, and after that every lane is READY. A block transfer while `drop_o` is high is ignored.
- R9: A restart offset of zero leaves all lanes READY even while a restart is pending.
- R10: A redirect that arrives while stale responses remain reloads both the squash count and the restart offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_fire_i | input | 1 | Fetch request issued this cycle |
| rsp_arrive_i | input | 1 | Memory response present this cycle |
| rsp_consume_i | input | 1 | Arriving response accepted by the fetch side |
| blk_xfer_i | input | 1 | Fetch block handed to decode this cycle |
| redir_val_i | input | 1 | Control-flow redirect this cycle |
| redir_addr_i | input | ADDR_W | Redirect target byte address |
| drop_o | output | 1 | Discard the response arriving this cycle |
| inflight_o | output | CNT_W | Outstanding request count |
| squash_o | output | CNT_W | Stale responses still to drain |
| req_allow_o | output | 1 | A new request may issue |
| lane_mask_o | output | NUM_LANES | Per-lane valid mask |
| lane_status_o | output | 2*NUM_LANES | Per-lane status, 2 bits per lane |

## Verification
Some properties are checked by assertions on every cycle:
- the in-flight count never passes its limit;
- the squash count never exceeds the in-flight count;
- a nonzero squash count always raises the drop output;
- a redirect always leaves a restart pending;
- the lane mask is always a contiguous run of ones reaching the top lane, and all ones when no restart is pending.

Other behaviours can only be shown by the bench's scenarios:
- the exact count loaded when requests and consumes coincide with a redirect;
- the offset taken from the address bits;
- a transfer during a drop being ignored;
- a second redirect in the middle of draining reloading both the count and the offset.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    typedef enum logic [1:0] {
        LANE_INVALID = 2'b00,
        LANE_READY   = 2'b01
    } lane_status_e;

    typedef struct packed {
        logic req;
        logic arrive;
        logic consume;
    } fsq_evt_t;

    function automatic lane_status_e status_of(input logic enabled);
        return enabled ? LANE_READY : LANE_INVALID;
    endfunction

endpackage

// File: rtl/fsq_inflight_ctr.sv
module fsq_inflight_ctr
    import fsq_pkg::*;
#(
    parameter int MAX_INFLIGHT = 4,
    parameter int CNT_W        = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  fsq_evt_t         evt_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] count_next_o,
    output logic             allow_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_INFLIGHT);

    logic [CNT_W-1:0] count_q;
    logic             take_req;
    logic             take_rsp;

    assign allow_o  = (count_q < LIMIT);
    assign take_req = evt_i.req && allow_o;
    assign take_rsp = evt_i.arrive && evt_i.consume && (count_q != '0);

    always_comb begin
        unique case ({take_req, take_rsp})
            2'b10:   count_next_o = count_q + 1'b1;
            2'b01:   count_next_o = count_q - 1'b1;
            default: count_next_o = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_next_o;
    end

    assign count_o = count_q;

    // R3: the count never exceeds the limit
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count_o <= LIMIT);

    // R3: a request refused at the limit leaves the count where it was
    a_r3_refused_req: assert property (@(posedge clk) disable iff (rst)
        (evt_i.req && !allow_o && !(evt_i.arrive && evt_i.consume)) |=> $stable(count_o));

endmodule

// File: rtl/fsq_squash_ctr.sv
module fsq_squash_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             redir_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             arrive_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)                               count_q <= '0;
        else if (redir_i)                      count_q <= load_i;
        else if (arrive_i && count_q != '0)    count_q <= count_q - 1'b1;
    end

    assign count_o = count_q;

    // R5: with no redirect and nothing arriving, the count holds
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!redir_i && !arrive_i) |=> $stable(count_o));

endmodule

// File: rtl/fsq_restart_mask.sv
module fsq_restart_mask
    import fsq_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = $clog2(NUM_LANES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   redir_i,
    input  logic [ADDR_W-1:0]      redir_addr_i,
    input  logic                   xfer_ok_i,
    output logic                   pend_o,
    output logic [NUM_LANES-1:0]   mask_o,
    output logic [2*NUM_LANES-1:0] status_o
);
    logic             pend_q;
    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            off_q  <= '0;
        end else if (redir_i) begin
            pend_q <= 1'b1;
            off_q  <= redir_addr_i[OFF_W+1:2];
        end else if (xfer_ok_i) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign mask_o[i]         = !pend_q || (i >= int'(off_q));
        assign status_o[2*i +: 2] = status_of(mask_o[i]);
        if (i < NUM_LANES - 1) begin : g_mono
            // R7: enabled lanes form a run that reaches the top lane
            a_r7_contiguous: assert property (@(posedge clk) disable iff (rst)
                mask_o[i] |-> mask_o[i+1]);
        end
    end

    // R8: a redirect always leaves a restart pending
    a_r8_set_on_redirect: assert property (@(posedge clk) disable iff (rst)
        redir_i |=> pend_o);

    // R8: with no restart pending every lane is enabled
    a_r8_all_lanes_idle: assert property (@(posedge clk) disable iff (rst)
        !pend_o |-> (&mask_o));

endmodule

// File: rtl/fetch_squash_tracker.sv
module fetch_squash_tracker
    import fsq_pkg::*;
#(
    parameter int NUM_LANES    = 4,
    parameter int ADDR_W       = 32,
    parameter int MAX_INFLIGHT = 4,
    parameter int CNT_W        = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_fire_i,
    input  logic                   rsp_arrive_i,
    input  logic                   rsp_consume_i,
    input  logic                   blk_xfer_i,
    input  logic                   redir_val_i,
    input  logic [ADDR_W-1:0]      redir_addr_i,
    output logic                   drop_o,
    output logic [CNT_W-1:0]       inflight_o,
    output logic [CNT_W-1:0]       squash_o,
    output logic                   req_allow_o,
    output logic [NUM_LANES-1:0]   lane_mask_o,
    output logic [2*NUM_LANES-1:0] lane_status_o
);
    fsq_evt_t         evt;
    logic [CNT_W-1:0] inflight_next;
    logic             restart_pend;

    assign evt = '{req: req_fire_i, arrive: rsp_arrive_i, consume: rsp_consume_i};

    fsq_inflight_ctr #(
        .MAX_INFLIGHT (MAX_INFLIGHT),
        .CNT_W        (CNT_W)
    ) u_inflight (
        .clk          (clk),
        .rst          (rst),
        .evt_i        (evt),
        .count_o      (inflight_o),
        .count_next_o (inflight_next),
        .allow_o      (req_allow_o)
    );

    fsq_squash_ctr #(
        .CNT_W    (CNT_W)
    ) u_squash (
        .clk      (clk),
        .rst      (rst),
        .redir_i  (redir_val_i),
        .load_i   (inflight_next),
        .arrive_i (rsp_arrive_i),
        .count_o  (squash_o)
    );

    assign drop_o = redir_val_i || (squash_o != '0);

    fsq_restart_mask #(
        .NUM_LANES    (NUM_LANES),
        .ADDR_W       (ADDR_W)
    ) u_mask (
        .clk          (clk),
        .rst          (rst),
        .redir_i      (redir_val_i),
        .redir_addr_i (redir_addr_i),
        .xfer_ok_i    (blk_xfer_i && !drop_o),
        .pend_o       (restart_pend),
        .mask_o       (lane_mask_o),
        .status_o     (lane_status_o)
    );

    // R4: stale responses never outnumber outstanding ones
    a_r4_squash_bounded: assert property (@(posedge clk) disable iff (rst)
        squash_o <= inflight_o);

    // R6: a nonzero squash count always drops
    a_r6_drop_when_squash: assert property (@(posedge clk) disable iff (rst)
        (squash_o != '0) |-> drop_o);

    // R8: a pending restart only clears through a transfer while not dropping
    a_r8_clear_needs_xfer: assert property (@(posedge clk) disable iff (rst)
        (restart_pend && !(blk_xfer_i && !drop_o)) |=> restart_pend);

endmodule

// File: tb/fetch_squash_tracker_tb_top.sv
module fetch_squash_tracker_tb_top;
    localparam int L = 4;
    localparam int AW = 32;
    localparam int MX = 4;
    localparam int CW = $clog2(MX + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 0, arr = 0, con = 0, xfer = 0, rv = 0;
    logic [AW-1:0] addr = '0;
    logic drop, allow;
    logic [CW-1:0] infl, sq;
    logic [L-1:0] mask;
    logic [2*L-1:0] stat;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    fetch_squash_tracker #(.NUM_LANES(L), .ADDR_W(AW), .MAX_INFLIGHT(MX)) dut_i (
        .clk(clk), .rst(rst), .req_fire_i(req), .rsp_arrive_i(arr),
        .rsp_consume_i(con), .blk_xfer_i(xfer), .redir_val_i(rv),
        .redir_addr_i(addr), .drop_o(drop), .inflight_o(infl),
        .squash_o(sq), .req_allow_o(allow), .lane_mask_o(mask),
        .lane_status_o(stat));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic a, input logic c,
                         input logic x, input logic v, input logic [AW-1:0] ad);
        req = r; arr = a; con = c; xfer = x; rv = v; addr = ad;
        #1;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        req = 0; arr = 0; con = 0; xfer = 0; rv = 0; addr = '0;
        #1;
    endtask

    task automatic cyc(input logic r, input logic a, input logic c,
                       input logic x, input logic v, input logic [AW-1:0] ad);
        drive(r, a, c, x, v, ad);
        tick();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        chk("R1 inflight", int'(infl), 0);
        chk("R1 squash", int'(sq), 0);
        chk("R1 mask", int'(mask), 15);
        chk("R1 status", int'(stat), 'h55);
        chk("R1 drop", int'(drop), 0);
    endtask

    task automatic t_count();
        repeat (3) cyc(1, 0, 0, 0, 0, 0);
        chk("R2 three requests", int'(infl), 3);
        cyc(1, 1, 1, 0, 0, 0);
        chk("R2 request with consume", int'(infl), 3);
        for (int k = 0; k < 3; k++) cyc(0, 1, 1, 0, 0, 0);
        chk("R2 drained", int'(infl), 0);
        cyc(0, 1, 1, 0, 0, 0);
        chk("R2 consume at zero", int'(infl), 0);
    endtask

    task automatic t_limit();
        repeat (4) cyc(1, 0, 0, 0, 0, 0);
        chk("R3 at limit", int'(infl), 4);
        chk("R3 allow low", int'(allow), 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R3 refused request", int'(infl), 4);
        cyc(0, 1, 1, 0, 0, 0);
        chk("R3 allow again", int'(allow), 1);
        repeat (3) cyc(0, 1, 1, 0, 0, 0);
        chk("R3 drained", int'(infl), 0);
    endtask

    task automatic t_squash_mid();
        repeat (3) cyc(1, 0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 1, 32'h0000_0108);
        chk("R6 drop on redirect", int'(drop), 1);
        tick();
        chk("R4 load net", int'(sq), 4);
        chk("R7 mask offset 2", int'(mask), 'hC);
        chk("R7 status offset 2", int'(stat), 'h50);
        cyc(0, 1, 1, 0, 0, 0);
        chk("R5 squash step", int'(sq), 3);
        chk("R6 drop while squash", int'(drop), 1);
        repeat (3) cyc(0, 1, 1, 0, 0, 0);
        chk("R5 squash drained", int'(sq), 0);
        chk("R6 drop released", int'(drop), 0);
        chk("R8 still pending", int'(mask), 'hC);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R8 cleared after transfer", int'(mask), 15);
        chk("R8 status all ready", int'(stat), 'h55);
    endtask

    task automatic t_xfer_drop();
        cyc(0, 0, 0, 1, 1, 32'h0000_000C);
        chk("R4 load zero", int'(sq), 0);
        chk("R8 transfer with redirect ignored", int'(mask), 8);
        chk("R7 status offset 3", int'(stat), 'h40);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 32'h0000_0004);
        chk("R4 load one", int'(sq), 1);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R8 transfer while squash ignored", int'(mask), 'hE);
        cyc(0, 1, 1, 0, 0, 0);
        chk("R5 back to zero", int'(sq), 0);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R8 cleared", int'(mask), 15);
    endtask

    task automatic t_zero_off();
        cyc(0, 0, 0, 0, 1, 32'h0000_0040);
        chk("R9 zero offset mask", int'(mask), 15);
        chk("R9 zero offset status", int'(stat), 'h55);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R9 after transfer", int'(mask), 15);
    endtask

    task automatic t_reredirect();
        repeat (2) cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 32'h0000_0008);
        chk("R10 first load", int'(sq), 2);
        cyc(0, 1, 1, 0, 0, 0);
        chk("R10 partial drain", int'(sq), 1);
        cyc(1, 0, 0, 0, 1, 32'h0000_0004);
        chk("R10 reload count", int'(sq), 2);
        chk("R10 reload offset", int'(mask), 'hE);
        repeat (2) cyc(0, 1, 1, 0, 0, 0);
        chk("R10 drained", int'(sq), 0);
        chk("R10 inflight zero", int'(infl), 0);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R10 cleared", int'(mask), 15);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_count();
                t_limit();
                t_squash_mid();
                t_xfer_drop();
                t_zero_off();
                t_reredirect();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule